// File: doc/BRIEF.md
# Separable Switch Allocator for a Virtual-Channel Router

This block decides, once per clock, which flits cross the crossbar of a wormhole router with several input ports, several output ports and several virtual channels (VCs) per port. The VCs of each port are split into equal, contiguous groups called virtual networks. For every input VC the router presents whether a flit is waiting, the flit's kind, its routed output port, the output VC it already holds (when it is not a packet head), and the time it was enqueued. For every output port it presents which output VCs are free and which ones have a buffer credit left.

Allocation has two stages. First, a round-robin arbiter at each input port chooses one eligible VC. A VC is eligible when its flit can be accepted downstream and, on an ordered virtual network, when no older waiting flit on the same port and network aims at the same output. Second, a round-robin arbiter at each output port chooses one of the input ports that picked it. A winning head flit is given the lowest free output VC of its own virtual network in that same step. The winners drive registered crossbar grants, credit-decrement strobes toward the output side and credit-return strobes (with an idle flag at the end of a packet) toward the upstream router.

Top module: `sa_switch_alloc`

## Requirements
- R1: Each input port picks at most one VC per cycle, searching round-robin from its pointer, and only among VCs that are ready and eligible; if any VC is eligible one is picked.
- R2: Each output port grants at most one input port per cycle, round-robin among the input ports whose picked VC routes to it; no input port is granted twice in a cycle.
- R3: After a pick or grant, that arbiter's pointer moves to the winner index plus one, wrapping to zero; it does not move in a cycle with no winner.
- R4: A flit of kind head (code 0) or single-flit packet (code 3) is eligible only if its routed output port has at least one free VC in the flit's own virtual network.
- R5: A flit of kind body (code 1) or tail (code 2) is eligible only if its held output VC has a credit at its routed output port.
- R6: A winning head or single flit is given the lowest-indexed free output VC of its virtual network; a body or tail winner keeps its held output VC; the chosen VC is reported with the grant.
- R7: Every grant raises the decrement strobe bit at position output_port*VCS+output_vc and a credit return on the winning input port naming the input VC.
- R8: The credit return carries the idle flag exactly when the granted flit is a tail or single flit.
- R9: The virtual network of VC v is v divided by the number of VCs per virtual network.
- R10: On a virtual network marked ordered, a VC is not eligible while another ready VC of the same port and network routes to the same output with a strictly smaller enqueue stamp.
- R11: Requests do not persist: a cycle whose inputs show no ready VC produces no grant and no credit strobe in the next cycle.
- R12: All outputs are registered and reflect the inputs sampled one clock edge earlier; synchronous reset clears all outputs and sets all pointers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_ready | input | NPORT*NVC | Flit waiting for allocation, one bit per input VC (port-major) |
| vc_kind | input | NPORT*NVC*2 | Flit kind per input VC: 0 head, 1 body, 2 tail, 3 single |
| vc_route | input | NPORT*NVC*PW | Routed output port per input VC |
| vc_held | input | NPORT*NVC*VW | Output VC already held by a body or tail flit |
| vc_stamp | input | NPORT*NVC*TSW | Enqueue stamp per input VC |
| op_free | input | NPORT*NVC | Free output VCs, bit port*NVC+vc |
| op_credit | input | NPORT*NVC | Output VCs with at least one credit, bit port*NVC+vc |
| xb_valid | output | NPORT | Crossbar grant per output port |
| xb_src_port | output | NPORT*PW | Granted input port per output port |
| xb_src_vc | output | NPORT*VW | Granted input VC per output port |
| xb_outvc | output | NPORT*VW | Output VC used by the granted flit |
| cr_dec | output | NPORT*NVC | Credit-decrement strobe, bit port*NVC+vc |
| cr_ret | output | NPORT | Credit return per input port |
| cr_ret_vc | output | NPORT*VW | Input VC whose slot is returned |
| cr_ret_idle | output | NPORT | Returned credit also marks the input VC idle |

## Verification
The two functions that most often meet in one cycle are an input pointer advancing for a VC that then loses at the output stage, and the output pointer advancing for the input port that won the same contention. Random traffic with few output ports per flit and directed runs where two inputs repeatedly aim at one output provoke this every cycle. A behavioural reference model in the bench keeps its own pointers and recomputes every grant, chosen output VC, decrement bit and credit return each cycle, so any drift of either pointer shows up as a mismatch in the very cycle it occurs.

// File: rtl/sa_pkg.sv
package sa_pkg;

   typedef enum logic [1:0] {
      FK_HEAD = 2'd0,
      FK_BODY = 2'd1,
      FK_TAIL = 2'd2,
      FK_SOLO = 2'd3
   } flit_kind_e;

   // head and single-flit packets still need an output VC
   function automatic logic kind_needs_vc(input logic [1:0] k);
      return (k == FK_HEAD) || (k == FK_SOLO);
   endfunction

   // tail and single-flit packets release the input VC
   function automatic logic kind_closes(input logic [1:0] k);
      return (k == FK_TAIL) || (k == FK_SOLO);
   endfunction

endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  req,
   output logic [IW-1:0] gnt_idx,
   output logic          gnt_any
);

   logic [IW-1:0] ptr;

   always_comb begin
      int c;
      gnt_idx = '0;
      gnt_any = 1'b0;
      for (int k = 0; k < N; k++) begin
         c = (int'(ptr) + k) % N;
         if (!gnt_any && req[c]) begin
            gnt_any = 1'b1;
            gnt_idx = IW'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         ptr <= '0;
      else if (gnt_any)
         ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
   end

   // R3: an idle arbiter keeps its pointer
   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !gnt_any |=> $stable(ptr));

   // R1: the winner is a requester, and some request always wins
   p_win_is_req_r1: assert property (@(posedge clk) disable iff (rst)
      gnt_any |-> req[gnt_idx]);
   p_work_conserve_r1: assert property (@(posedge clk) disable iff (rst)
      (|req) |-> gnt_any);

endmodule

// File: rtl/sa_input_stage.sv
module sa_input_stage
   import sa_pkg::*;
#(
   parameter int          NPORT   = 4,
   parameter int          NVC     = 4,
   parameter int          VPV     = 2,
   parameter int          TSW     = 8,
   parameter logic [31:0] ORDERED = 32'h1,
   localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int VW = (NVC > 1) ? $clog2(NVC) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NVC-1:0]       ready,
   input  logic [NVC*2-1:0]     kind,
   input  logic [NVC*PW-1:0]    route,
   input  logic [NVC*VW-1:0]    held_vc,
   input  logic [NVC*TSW-1:0]   stamp,
   input  logic [NPORT*NVC-1:0] free_map,
   input  logic [NPORT*NVC-1:0] credit_map,
   output logic                 pick_valid,
   output logic [VW-1:0]        pick_vc,
   output logic [PW-1:0]        pick_port,
   output logic                 pick_alloc,
   output logic                 pick_close,
   output logic [VW-1:0]        pick_held
);

   logic [NVC-1:0] elig;

   for (genvar v = 0; v < NVC; v++) begin : g_vc
      localparam int VN = v / VPV;
      logic [PW-1:0]  rp;
      logic [VW-1:0]  hv;
      logic [VPV-1:0] vn_free;
      logic           head, cred_ok, room_ok, older_seen;

      assign rp   = route[v*PW +: PW];
      assign hv   = held_vc[v*VW +: VW];
      assign head = kind_needs_vc(kind[v*2 +: 2]);

      always_comb vn_free = free_map[int'(rp)*NVC + VN*VPV +: VPV];
      assign cred_ok = credit_map[int'(rp)*NVC + int'(hv)];
      assign room_ok = head ? (|vn_free) : cred_ok;

      if (ORDERED[VN]) begin : g_ord
         always_comb begin
            older_seen = 1'b0;
            for (int u = VN*VPV; u < VN*VPV + VPV; u++) begin
               if (u != v && ready[u] && route[u*PW +: PW] == rp &&
                   stamp[u*TSW +: TSW] < stamp[v*TSW +: TSW])
                  older_seen = 1'b1;
            end
         end
      end else begin : g_free_order
         assign older_seen = 1'b0;
      end

      assign elig[v] = ready[v] && room_ok && !older_seen;
   end

   logic [VW-1:0] arb_idx;
   logic          arb_any;

   sa_rr_arb #(.N(NVC)) u_vc_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (elig),
      .gnt_idx (arb_idx),
      .gnt_any (arb_any)
   );

   assign pick_valid = arb_any;
   assign pick_vc    = arb_idx;
   assign pick_port  = route[int'(arb_idx)*PW +: PW];
   assign pick_alloc = kind_needs_vc(kind[int'(arb_idx)*2 +: 2]);
   assign pick_close = kind_closes(kind[int'(arb_idx)*2 +: 2]);
   assign pick_held  = held_vc[int'(arb_idx)*VW +: VW];

   // R4: a picked head flit sees a free VC of its network at its output
   p_head_room_r4: assert property (@(posedge clk) disable iff (rst)
      (pick_valid && pick_alloc) |->
         (|free_map[int'(pick_port)*NVC + (int'(pick_vc)/VPV)*VPV +: VPV]));

   // R5: a picked body or tail flit sees a credit on its held VC
   p_body_credit_r5: assert property (@(posedge clk) disable iff (rst)
      (pick_valid && !pick_alloc) |->
         credit_map[int'(pick_port)*NVC + int'(pick_held)]);

endmodule

// File: rtl/sa_output_stage.sv
module sa_output_stage #(
   parameter int NPORT   = 4,
   parameter int NVC     = 4,
   parameter int VPV     = 2,
   parameter int MY_PORT = 0,
   localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int VW = (NVC > 1) ? $clog2(NVC) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NPORT-1:0]    req_valid,
   input  logic [NPORT*PW-1:0] req_port,
   input  logic [NPORT*VW-1:0] req_vc,
   input  logic [NPORT-1:0]    req_alloc,
   input  logic [NPORT*VW-1:0] req_held,
   input  logic [NVC-1:0]      free_here,
   output logic                win,
   output logic [PW-1:0]       win_src,
   output logic [VW-1:0]       win_vc,
   output logic [VW-1:0]       win_outvc
);

   logic [NPORT-1:0] hits;

   for (genvar p = 0; p < NPORT; p++) begin : g_hit
      assign hits[p] = req_valid[p] && (req_port[p*PW +: PW] == PW'(MY_PORT));
   end

   logic [PW-1:0] arb_idx;
   logic          arb_any;

   sa_rr_arb #(.N(NPORT)) u_port_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (hits),
      .gnt_idx (arb_idx),
      .gnt_any (arb_any)
   );

   logic [VW-1:0] cand_vc;
   logic [VW-1:0] low_free;

   assign cand_vc = req_vc[int'(arb_idx)*VW +: VW];

   // lowest free output VC inside the winner's virtual network
   always_comb begin
      int  base;
      logic found;
      base     = (int'(cand_vc) / VPV) * VPV;
      low_free = '0;
      found    = 1'b0;
      for (int k = 0; k < VPV; k++) begin
         if (!found && free_here[base + k]) begin
            low_free = VW'(base + k);
            found    = 1'b1;
         end
      end
   end

   assign win       = arb_any;
   assign win_src   = arb_any ? arb_idx : '0;
   assign win_vc    = arb_any ? cand_vc : '0;
   assign win_outvc = !arb_any ? '0 :
                      req_alloc[arb_idx] ? low_free : req_held[int'(arb_idx)*VW +: VW];

   // R6: a freshly allocated VC is free and lies in the flit's own network (R9)
   p_outvc_free_r6: assert property (@(posedge clk) disable iff (rst)
      (win && req_alloc[win_src]) |->
         (free_here[win_outvc] && (int'(win_outvc)/VPV == int'(win_vc)/VPV)));

   // R2: the granted input actually asked for this port
   p_grant_asked_r2: assert property (@(posedge clk) disable iff (rst)
      win |-> hits[win_src]);

endmodule

// File: rtl/sa_switch_alloc.sv
module sa_switch_alloc #(
   parameter int          NPORT   = 4,
   parameter int          NVC     = 4,
   parameter int          VPV     = 2,
   parameter int          TSW     = 8,
   parameter logic [31:0] ORDERED = 32'h1,
   localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int VW    = (NVC > 1) ? $clog2(NVC) : 1,
   localparam int NVNET = NVC / VPV
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NPORT*NVC-1:0]     vc_ready,
   input  logic [NPORT*NVC*2-1:0]   vc_kind,
   input  logic [NPORT*NVC*PW-1:0]  vc_route,
   input  logic [NPORT*NVC*VW-1:0]  vc_held,
   input  logic [NPORT*NVC*TSW-1:0] vc_stamp,
   input  logic [NPORT*NVC-1:0]     op_free,
   input  logic [NPORT*NVC-1:0]     op_credit,
   output logic [NPORT-1:0]         xb_valid,
   output logic [NPORT*PW-1:0]      xb_src_port,
   output logic [NPORT*VW-1:0]      xb_src_vc,
   output logic [NPORT*VW-1:0]      xb_outvc,
   output logic [NPORT*NVC-1:0]     cr_dec,
   output logic [NPORT-1:0]         cr_ret,
   output logic [NPORT*VW-1:0]      cr_ret_vc,
   output logic [NPORT-1:0]         cr_ret_idle
);

   // elaboration-time parameter checks
   if (NPORT < 2) begin : g_bad_nport
      $error("sa_switch_alloc: NPORT must be at least 2");
   end
   if (VPV < 1 || (NVC % VPV) != 0) begin : g_bad_vpv
      $error("sa_switch_alloc: NVC must be a multiple of VPV");
   end
   if (NVNET > 32) begin : g_bad_nvnet
      $error("sa_switch_alloc: at most 32 virtual networks");
   end
   if (TSW < 1) begin : g_bad_tsw
      $error("sa_switch_alloc: TSW must be positive");
   end

   // ---------------- stage one: one pick per input port ----------------
   logic [NPORT-1:0]    pk_valid, pk_alloc, pk_close;
   logic [NPORT*PW-1:0] pk_port;
   logic [NPORT*VW-1:0] pk_vc, pk_held;

   for (genvar p = 0; p < NPORT; p++) begin : g_in
      sa_input_stage #(
         .NPORT(NPORT), .NVC(NVC), .VPV(VPV), .TSW(TSW), .ORDERED(ORDERED)
      ) u_in (
         .clk        (clk),
         .rst        (rst),
         .ready      (vc_ready[p*NVC +: NVC]),
         .kind       (vc_kind[p*NVC*2 +: NVC*2]),
         .route      (vc_route[p*NVC*PW +: NVC*PW]),
         .held_vc    (vc_held[p*NVC*VW +: NVC*VW]),
         .stamp      (vc_stamp[p*NVC*TSW +: NVC*TSW]),
         .free_map   (op_free),
         .credit_map (op_credit),
         .pick_valid (pk_valid[p]),
         .pick_vc    (pk_vc[p*VW +: VW]),
         .pick_port  (pk_port[p*PW +: PW]),
         .pick_alloc (pk_alloc[p]),
         .pick_close (pk_close[p]),
         .pick_held  (pk_held[p*VW +: VW])
      );
   end

   // ---------------- stage two: one grant per output port ----------------
   logic [NPORT-1:0]    w_any;
   logic [NPORT*PW-1:0] w_src;
   logic [NPORT*VW-1:0] w_vc, w_ovc;

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      sa_output_stage #(
         .NPORT(NPORT), .NVC(NVC), .VPV(VPV), .MY_PORT(o)
      ) u_out (
         .clk       (clk),
         .rst       (rst),
         .req_valid (pk_valid),
         .req_port  (pk_port),
         .req_vc    (pk_vc),
         .req_alloc (pk_alloc),
         .req_held  (pk_held),
         .free_here (op_free[o*NVC +: NVC]),
         .win       (w_any[o]),
         .win_src   (w_src[o*PW +: PW]),
         .win_vc    (w_vc[o*VW +: VW]),
         .win_outvc (w_ovc[o*VW +: VW])
      );
   end

   // ---------------- strobes derived from the winners ----------------
   logic [NPORT*NVC-1:0] dec_n;
   logic [NPORT-1:0]     ret_n, idle_n;
   logic [NPORT*VW-1:0]  ret_vc_n;

   always_comb begin
      dec_n = '0;
      for (int o = 0; o < NPORT; o++) begin
         if (w_any[o])
            dec_n[o*NVC + int'(w_ovc[o*VW +: VW])] = 1'b1;
      end
   end

   always_comb begin
      ret_n    = '0;
      idle_n   = '0;
      ret_vc_n = '0;
      for (int p = 0; p < NPORT; p++) begin
         for (int o = 0; o < NPORT; o++) begin
            if (w_any[o] && w_src[o*PW +: PW] == PW'(p))
               ret_n[p] = 1'b1;
         end
         if (ret_n[p]) begin
            ret_vc_n[p*VW +: VW] = pk_vc[p*VW +: VW];
            idle_n[p]            = pk_close[p];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         xb_valid    <= '0;
         xb_src_port <= '0;
         xb_src_vc   <= '0;
         xb_outvc    <= '0;
         cr_dec      <= '0;
         cr_ret      <= '0;
         cr_ret_vc   <= '0;
         cr_ret_idle <= '0;
      end else begin
         xb_valid    <= w_any;
         xb_src_port <= w_src;
         xb_src_vc   <= w_vc;
         xb_outvc    <= w_ovc;
         cr_dec      <= dec_n;
         cr_ret      <= ret_n;
         cr_ret_vc   <= ret_vc_n;
         cr_ret_idle <= idle_n;
      end
   end

   // R7: one decrement and one return per grant
   p_dec_count_r7: assert property (@(posedge clk) disable iff (rst)
      $countones(cr_dec) == $countones(xb_valid));
   p_ret_count_r7: assert property (@(posedge clk) disable iff (rst)
      $countones(cr_ret) == $countones(xb_valid));

   // R8: idle indication only rides on a returned credit
   p_idle_on_ret_r8: assert property (@(posedge clk) disable iff (rst)
      (cr_ret_idle & ~cr_ret) == '0);

   // R11 / R12: nothing ready now means nothing granted next cycle
   p_no_stale_r11: assert property (@(posedge clk) disable iff (rst)
      (vc_ready == '0) |=> ((xb_valid == '0) && (cr_ret == '0)));

   for (genvar o = 0; o < NPORT; o++) begin : g_chk
      // R7: the decrement lands on the reported output VC
      p_dec_at_vc_r7: assert property (@(posedge clk) disable iff (rst)
         xb_valid[o] |-> cr_dec[o*NVC + int'(xb_outvc[o*VW +: VW])]);
      // R2: the granted source port returns a credit
      p_src_returns_r2: assert property (@(posedge clk) disable iff (rst)
         xb_valid[o] |-> cr_ret[xb_src_port[o*PW +: PW]]);
   end

endmodule

// File: tb/sa_switch_alloc_tb.sv
`timescale 1ns/1ps
module sa_switch_alloc_tb_top;

   localparam int NP  = 4;
   localparam int NV  = 4;
   localparam int VPV = 2;
   localparam int TSW = 8;
   localparam logic [31:0] ORD = 32'h1;   // virtual network 0 ordered
   localparam int PW  = 2;
   localparam int VW  = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;   // 125 MHz

   logic [NP*NV-1:0]     vc_ready;
   logic [NP*NV*2-1:0]   vc_kind;
   logic [NP*NV*PW-1:0]  vc_route;
   logic [NP*NV*VW-1:0]  vc_held;
   logic [NP*NV*TSW-1:0] vc_stamp;
   logic [NP*NV-1:0]     op_free, op_credit;
   logic [NP-1:0]        xb_valid, cr_ret, cr_ret_idle;
   logic [NP*PW-1:0]     xb_src_port;
   logic [NP*VW-1:0]     xb_src_vc, xb_outvc, cr_ret_vc;
   logic [NP*NV-1:0]     cr_dec;

   sa_switch_alloc #(.NPORT(NP), .NVC(NV), .VPV(VPV), .TSW(TSW), .ORDERED(ORD)) dut_i (
      .clk(clk), .rst(rst),
      .vc_ready(vc_ready), .vc_kind(vc_kind), .vc_route(vc_route),
      .vc_held(vc_held), .vc_stamp(vc_stamp),
      .op_free(op_free), .op_credit(op_credit),
      .xb_valid(xb_valid), .xb_src_port(xb_src_port), .xb_src_vc(xb_src_vc),
      .xb_outvc(xb_outvc), .cr_dec(cr_dec), .cr_ret(cr_ret),
      .cr_ret_vc(cr_ret_vc), .cr_ret_idle(cr_ret_idle)
   );

   // stimulus state
   logic           rdy  [NP][NV];
   logic [1:0]     knd  [NP][NV];
   logic [PW-1:0]  rte  [NP][NV];
   logic [VW-1:0]  hvc  [NP][NV];
   logic [TSW-1:0] stp  [NP][NV];
   logic           ofr  [NP][NV];
   logic           ocr  [NP][NV];

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         for (int v = 0; v < NV; v++) begin
            vc_ready[p*NV+v]             = rdy[p][v];
            vc_kind[(p*NV+v)*2 +: 2]     = knd[p][v];
            vc_route[(p*NV+v)*PW +: PW]  = rte[p][v];
            vc_held[(p*NV+v)*VW +: VW]   = hvc[p][v];
            vc_stamp[(p*NV+v)*TSW +: TSW] = stp[p][v];
            op_free[p*NV+v]              = ofr[p][v];
            op_credit[p*NV+v]            = ocr[p][v];
         end
      end
   end

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int cyc    = 0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int ip [NP];
   int op [NP];
   int exp_xv [NP], exp_src [NP], exp_svc [NP], exp_ovc [NP];
   int exp_ret [NP], exp_rvc [NP], exp_idle [NP];
   int exp_dec;

   function automatic bit can_go(input int p, input int v);
      int o, vn;
      o  = int'(rte[p][v]);
      vn = v / VPV;
      if (!rdy[p][v]) return 1'b0;
      if (knd[p][v] == 2'd0 || knd[p][v] == 2'd3) begin
         bit any_free;
         any_free = 1'b0;
         for (int j = 0; j < VPV; j++) if (ofr[o][vn*VPV+j]) any_free = 1'b1;
         if (!any_free) return 1'b0;
      end else if (!ocr[o][int'(hvc[p][v])]) return 1'b0;
      if (ORD[vn]) begin
         for (int u = vn*VPV; u < vn*VPV + VPV; u++)
            if (u != v && rdy[p][u] && rte[p][u] == rte[p][v] && stp[p][u] < stp[p][v])
               return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic model_step();
      int req [NP];
      int v, p, ov, base;
      for (int i = 0; i < NP; i++) begin
         exp_xv[i] = 0; exp_src[i] = 0; exp_svc[i] = 0; exp_ovc[i] = 0;
         exp_ret[i] = 0; exp_rvc[i] = 0; exp_idle[i] = 0;
      end
      exp_dec = 0;
      for (int q = 0; q < NP; q++) begin
         req[q] = -1;
         for (int k = 0; k < NV; k++) begin
            v = (ip[q] + k) % NV;
            if (req[q] < 0 && can_go(q, v)) begin
               req[q] = v;
               ip[q]  = (v + 1) % NV;
            end
         end
      end
      for (int o = 0; o < NP; o++) begin
         for (int k = 0; k < NP; k++) begin
            p = (op[o] + k) % NP;
            if (exp_xv[o] == 0 && req[p] >= 0 && int'(rte[p][req[p]]) == o) begin
               exp_xv[o]  = 1;
               exp_src[o] = p;
               exp_svc[o] = req[p];
               if (knd[p][req[p]] == 2'd0 || knd[p][req[p]] == 2'd3) begin
                  base = (req[p] / VPV) * VPV;
                  ov   = -1;
                  for (int j = 0; j < VPV; j++) if (ov < 0 && ofr[o][base+j]) ov = base + j;
               end else ov = int'(hvc[p][req[p]]);
               exp_ovc[o]  = ov;
               exp_dec     = exp_dec | (1 << (o*NV + ov));
               exp_ret[p]  = 1;
               exp_rvc[p]  = req[p];
               exp_idle[p] = (knd[p][req[p]] == 2'd2 || knd[p][req[p]] == 2'd3) ? 1 : 0;
               op[o] = (p + 1) % NP;
            end
         end
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         for (int i = 0; i < NP; i++) begin
            ip[i] = 0; op[i] = 0;
            exp_xv[i] = 0; exp_ret[i] = 0; exp_idle[i] = 0;
         end
         exp_dec = 0;
      end else model_step();
   end

   // compare against the model on every cycle, away from the edge
   always @(negedge clk) begin
      if (cyc >= 2 && !done) begin
         for (int o = 0; o < NP; o++) begin
            check($sformatf("R2 grant valid out%0d", o), int'(xb_valid[o]), exp_xv[o]);
            if (exp_xv[o] != 0) begin
               check($sformatf("R2 src port out%0d", o), int'(xb_src_port[o*PW +: PW]), exp_src[o]);
               check($sformatf("R1 src vc out%0d", o), int'(xb_src_vc[o*VW +: VW]), exp_svc[o]);
               check($sformatf("R6 out vc out%0d", o), int'(xb_outvc[o*VW +: VW]), exp_ovc[o]);
            end
         end
         check("R7 decrement strobes", int'(cr_dec), exp_dec);
         for (int p = 0; p < NP; p++) begin
            check($sformatf("R7 credit return in%0d", p), int'(cr_ret[p]), exp_ret[p]);
            check($sformatf("R8 idle flag in%0d", p), int'(cr_ret_idle[p]), exp_idle[p]);
            if (exp_ret[p] != 0)
               check($sformatf("R7 return vc in%0d", p), int'(cr_ret_vc[p*VW +: VW]), exp_rvc[p]);
         end
      end
   end

   task automatic clear_inputs();
      for (int p = 0; p < NP; p++)
         for (int v = 0; v < NV; v++) begin
            rdy[p][v] = 1'b0; knd[p][v] = 2'd0; rte[p][v] = '0;
            hvc[p][v] = '0;   stp[p][v] = '0;   ofr[p][v] = 1'b0; ocr[p][v] = 1'b0;
         end
   endtask

   task automatic random_inputs();
      for (int p = 0; p < NP; p++)
         for (int v = 0; v < NV; v++) begin
            rdy[p][v] = ($urandom % 3) != 0;
            knd[p][v] = 2'($urandom % 4);
            rte[p][v] = PW'($urandom % NP);
            hvc[p][v] = VW'($urandom % NV);
            stp[p][v] = TSW'($urandom % 16);
            ofr[p][v] = 1'($urandom % 2);
            ocr[p][v] = 1'($urandom % 2);
         end
   endtask

   initial begin
      int s_prev, s_now, v_first;
      clear_inputs();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R12 reset grants", int'(xb_valid), 0);
      check("R12 reset decrements", int'(cr_dec), 0);
      check("R12 reset returns", int'(cr_ret), 0);
      rst = 1'b0;

      // random traffic, model compared each cycle
      repeat (600) begin
         random_inputs();
         @(negedge clk);
      end

      // R4 / R9: head flit of network 1 with only network 0 free
      clear_inputs();
      @(negedge clk);
      ofr[1][0] = 1'b1; ofr[1][1] = 1'b1;
      rdy[0][2] = 1'b1; knd[0][2] = 2'd0; rte[0][2] = 2'd1;
      @(negedge clk);
      check("R4 no free vc in own network blocks", int'(xb_valid[1]), 0);
      check("R9 no credit return when blocked", int'(cr_ret[0]), 0);
      ofr[1][3] = 1'b1;
      @(negedge clk);
      check("R4 free vc allows grant", int'(xb_valid[1]), 1);
      check("R6 lowest free vc 3", int'(xb_outvc[1*VW +: VW]), 3);
      check("R7 decrement bit 7", int'(cr_dec[1*NV+3]), 1);
      check("R8 head has no idle", int'(cr_ret_idle[0]), 0);
      ofr[1][2] = 1'b1;
      @(negedge clk);
      check("R6 lowest free vc 2", int'(xb_outvc[1*VW +: VW]), 2);

      // R5: body flit credit gating
      clear_inputs();
      @(negedge clk);
      rdy[0][0] = 1'b1; knd[0][0] = 2'd1; hvc[0][0] = 2'd1; rte[0][0] = 2'd2;
      @(negedge clk);
      check("R5 body without credit blocked", int'(xb_valid[2]), 0);
      ocr[2][1] = 1'b1;
      @(negedge clk);
      check("R5 body with credit granted", int'(xb_valid[2]), 1);
      check("R6 body keeps held vc", int'(xb_outvc[2*VW +: VW]), 1);
      check("R7 decrement bit 9", int'(cr_dec[2*NV+1]), 1);
      check("R8 body has no idle", int'(cr_ret_idle[0]), 0);
      knd[0][0] = 2'd2;
      @(negedge clk);
      check("R8 tail sets idle", int'(cr_ret_idle[0]), 1);
      check("R7 return names vc 0", int'(cr_ret_vc[0*VW +: VW]), 0);

      // R10: ordered network lets the older flit go first
      clear_inputs();
      @(negedge clk);
      for (int v = 0; v < NV; v++) ofr[3][v] = 1'b1;
      rdy[1][0] = 1'b1; rte[1][0] = 2'd3; stp[1][0] = 8'd20;
      rdy[1][1] = 1'b1; rte[1][1] = 2'd3; stp[1][1] = 8'd10;
      @(negedge clk);
      check("R10 older vc 1 wins", int'(xb_src_vc[3*VW +: VW]), 1);
      stp[1][0] = 8'd5;
      @(negedge clk);
      check("R10 older vc 0 wins", int'(xb_src_vc[3*VW +: VW]), 0);

      // R1: unordered network rotates between its VCs
      rdy[1][0] = 1'b0; rdy[1][1] = 1'b0;
      rdy[1][2] = 1'b1; rte[1][2] = 2'd3; stp[1][2] = 8'd20;
      rdy[1][3] = 1'b1; rte[1][3] = 2'd3; stp[1][3] = 8'd10;
      @(negedge clk);
      v_first = int'(xb_src_vc[3*VW +: VW]);
      @(negedge clk);
      check("R1 input pointer rotates", int'(xb_src_vc[3*VW +: VW]) == v_first ? 1 : 0, 0);

      // R3: two inputs contending for output 0 alternate
      clear_inputs();
      @(negedge clk);
      for (int v = 0; v < NV; v++) ofr[0][v] = 1'b1;
      rdy[0][0] = 1'b1; knd[0][0] = 2'd3; rte[0][0] = 2'd0;
      rdy[2][0] = 1'b1; knd[2][0] = 2'd3; rte[2][0] = 2'd0;
      @(negedge clk);
      s_prev = int'(xb_src_port[0 +: PW]);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         s_now = int'(xb_src_port[0 +: PW]);
         check("R3 output pointer alternates", (s_now != s_prev && (s_now == 0 || s_now == 2)) ? 1 : 0, 1);
         s_prev = s_now;
      end

      // R11: the loser of the last contention does not linger
      clear_inputs();
      @(negedge clk);
      check("R11 no stale grant", int'(xb_valid), 0);
      check("R11 no stale return", int'(cr_ret), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R12 actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule